// File: doc/BRIEF.md
# Packed Min/Max ALU with Secondary Combine

This block is one execution slot for a video-style integer min/max instruction. Each cycle it may accept a 64-bit instruction word, three 32-bit register operands A, B and C, and an input valid strobe. A primary stage picks the smaller or larger of A and B. A secondary stage then combines that value with C in one of four ways. It can insert a low slice of the value into a chosen field of C. It can add the value to C. It can take a second minimum or maximum against C. Or it can pass the value through unchanged. The primary and secondary comparisons each have their own signedness control.

The result and its valid strobe are registered, so they appear one clock after the input. Only the full-width source formats with a register B operand are supported. The unit rejects any other encoding: it raises a one-cycle unsupported flag and keeps its result register as it was. A word that does not carry the min/max opcode is ignored. The decode, primary comparator and secondary combiner are separate modules, and one comparator design serves both stages.

Top module: `vid_minmax_unit`

## Requirements
- R1: A word is accepted only when bits 63:57 equal 7'b0011101. With any other value the next cycle shows out_valid=0 and out_unsup=0, and out_result does not change.
- R2: The result and the flags are registered and appear on the clock edge after the one that samples in_valid. A synchronous active-high reset clears out_valid, out_unsup and out_result to 0.
- R3: Bit 56 picks the primary operation: 1 takes max(A,B) and 0 takes min(A,B). The comparison is two's-complement when bit 48 is 1 and unsigned when it is 0.
- R4: The secondary code sits in bits 53:51. Codes 0 to 3 insert a slice of the primary value P into C and keep every other bit of C. Code 0 writes P[15:0] into C[31:16]. Code 1 writes P[15:0] into C[15:0]. Code 2 writes P[7:0] into C[7:0]. Code 3 writes P[7:0] into C[23:16].
- R5: Secondary code 4 gives P+C modulo 2^32.
- R6: Secondary code 5 gives min(P,C) and code 6 gives max(P,C). These two compare two's-complement when bit 54 is 1 and unsigned when it is 0, whatever bit 48 says.
- R7: Secondary code 7 gives P unchanged.
- R8: A matching word is unsupported when any of these holds: bits 38:37 are not 2'b11, bits 30:29 are not 2'b11, bit 50 is 0, bit 48 differs from bit 49, or bit 55 is 1. In that case the next cycle shows out_unsup=1 and out_valid=0, and out_result keeps its old value.
- R9: While in_valid is 0 the next cycle shows out_valid=0 and out_unsup=0, and out_result keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 64 | Instruction word |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opc | input | 32 | Operand C |
| out_valid | output | 1 | out_result was updated this cycle |
| out_result | output | 32 | Registered result |
| out_unsup | output | 1 | Previous accepted word was unsupported |

## Verification
The bench feeds operand pairs whose order differs between the signed and unsigned views. A design that ignores bit 48 or bit 54, or that swaps those two flags between the stages, picks the wrong operand. Each field insert uses a C with every bit set and a primary value with a distinct pattern, so an insert at the wrong position or with the wrong width changes C bits that should have been kept. The add test wraps past 2^32 to catch a widened or truncated sum. Each unsupported condition is applied on its own after a good result, so a design that lets the bad word through, drops the flag, or overwrites the held result shows up at the ports.

// File: rtl/vmm_pkg.sv
package vmm_pkg;

   localparam int INSN_W      = 64;
   localparam logic [6:0] OPC_MINMAX = 7'b0011101;
   localparam int OPC_HI      = 63;
   localparam int OPC_LO      = 57;
   localparam int BIT_MX      = 56;
   localparam int BIT_SAT     = 55;
   localparam int BIT_DSGN    = 54;
   localparam int SEC_HI      = 53;
   localparam int SEC_LO      = 51;
   localparam int BIT_BREG    = 50;
   localparam int BIT_BSGN    = 49;
   localparam int BIT_ASGN    = 48;
   localparam int FMTA_HI     = 38;
   localparam int FMTA_LO     = 37;
   localparam int FMTB_HI     = 30;
   localparam int FMTB_LO     = 29;
   localparam logic [1:0] FMT_FULL = 2'b11;

   typedef enum logic [2:0] {
      SEC_INS_HI16 = 3'd0,
      SEC_INS_LO16 = 3'd1,
      SEC_INS_B0   = 3'd2,
      SEC_INS_B2   = 3'd3,
      SEC_ADD      = 3'd4,
      SEC_MIN      = 3'd5,
      SEC_MAX      = 3'd6,
      SEC_PASS     = 3'd7
   } sec_op_e;

   typedef struct packed {
      logic    hit;
      logic    legal;
      logic    prim_max;
      logic    prim_signed;
      logic    sec_signed;
      sec_op_e sec_op;
   } vmm_dec_t;

endpackage

// File: rtl/vmm_decode.sv
module vmm_decode
   import vmm_pkg::*;
(
   input  logic [INSN_W-1:0] word,
   output vmm_dec_t          dec
);
   logic [1:0] fmt_a;
   logic [1:0] fmt_b;
   logic       sign_agree;

   always_comb begin
      fmt_a      = word[FMTA_HI:FMTA_LO];
      fmt_b      = word[FMTB_HI:FMTB_LO];
      sign_agree = (word[BIT_ASGN] == word[BIT_BSGN]);

      dec.hit         = (word[OPC_HI:OPC_LO] == OPC_MINMAX);
      dec.legal       = (fmt_a == FMT_FULL) && (fmt_b == FMT_FULL) &&
                        word[BIT_BREG] && sign_agree && !word[BIT_SAT];
      dec.prim_max    = word[BIT_MX];
      dec.prim_signed = word[BIT_ASGN];
      dec.sec_signed  = word[BIT_DSGN];
      dec.sec_op      = sec_op_e'(word[SEC_HI:SEC_LO]);
   end
endmodule

// File: rtl/vmm_minmax.sv
module vmm_minmax #(
   parameter int W       = 32,
   parameter bit USE_SUB = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         is_signed,
   input  logic         take_max,
   output logic [W-1:0] y
);
   logic a_lt_b;

   generate
      if (USE_SUB) begin : g_sub
         logic [W:0] diff;
         logic       ext_a;
         logic       ext_b;
         always_comb begin
            ext_a  = is_signed & a[W-1];
            ext_b  = is_signed & b[W-1];
            diff   = {ext_a, a} - {ext_b, b};
            a_lt_b = diff[W];
         end
      end else begin : g_rel
         always_comb begin
            if (is_signed) a_lt_b = ($signed(a) < $signed(b));
            else           a_lt_b = (a < b);
         end
      end
   endgenerate

   always_comb begin
      if (take_max) y = a_lt_b ? b : a;
      else          y = a_lt_b ? a : b;
   end
endmodule

// File: rtl/vmm_combine.sv
module vmm_combine
   import vmm_pkg::*;
#(
   parameter int W       = 32,
   parameter bit USE_SUB = 1'b1
) (
   input  logic [W-1:0] prim,
   input  logic [W-1:0] c,
   input  sec_op_e      op,
   input  logic         sec_signed,
   output logic [W-1:0] y
);
   localparam int HALF = W / 2;
   localparam int QRTR = W / 4;

   logic [W-1:0] mm_out;
   logic         want_max;

   assign want_max = (op == SEC_MAX);

   vmm_minmax #(.W(W), .USE_SUB(USE_SUB)) u_sec_mm (
      .a         (prim),
      .b         (c),
      .is_signed (sec_signed),
      .take_max  (want_max),
      .y         (mm_out)
   );

   always_comb begin
      y = c;
      unique case (op)
         SEC_INS_HI16: y[W-1:HALF]         = prim[HALF-1:0];
         SEC_INS_LO16: y[HALF-1:0]         = prim[HALF-1:0];
         SEC_INS_B0:   y[QRTR-1:0]         = prim[QRTR-1:0];
         SEC_INS_B2:   y[HALF+QRTR-1:HALF] = prim[QRTR-1:0];
         SEC_ADD:      y = prim + c;
         SEC_MIN,
         SEC_MAX:      y = mm_out;
         SEC_PASS:     y = prim;
         default:      y = prim;
      endcase
   end
endmodule

// File: rtl/vid_minmax_unit.sv
module vid_minmax_unit
   import vmm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit USE_SUB = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [INSN_W-1:0]   insn,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   input  logic [DATA_W-1:0]   opc,
   output logic                out_valid,
   output logic [DATA_W-1:0]   out_result,
   output logic                out_unsup
);
   generate
      if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_width
         $error("vid_minmax_unit: DATA_W must be a multiple of 4 and at least 8");
      end
   endgenerate

   vmm_dec_t          dec;
   logic [DATA_W-1:0] prim_val;
   logic [DATA_W-1:0] final_val;
   logic              take;
   logic              accept;
   logic              reject;

   vmm_decode u_dec (
      .word (insn),
      .dec  (dec)
   );

   vmm_minmax #(.W(DATA_W), .USE_SUB(USE_SUB)) u_prim_mm (
      .a         (opa),
      .b         (opb),
      .is_signed (dec.prim_signed),
      .take_max  (dec.prim_max),
      .y         (prim_val)
   );

   vmm_combine #(.W(DATA_W), .USE_SUB(USE_SUB)) u_comb (
      .prim       (prim_val),
      .c          (opc),
      .op         (dec.sec_op),
      .sec_signed (dec.sec_signed),
      .y          (final_val)
   );

   assign take   = in_valid & dec.hit;
   assign accept = take & dec.legal;
   assign reject = take & ~dec.legal;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_unsup  <= 1'b0;
         out_result <= '0;
      end else begin
         out_valid <= accept;
         out_unsup <= reject;
         if (accept) out_result <= final_val;
      end
   end
endmodule

module vmm_checker
   import vmm_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic [INSN_W-1:0]   insn,
   input logic [DATA_W-1:0]   opc,
   input logic                out_valid,
   input logic [DATA_W-1:0]   out_result,
   input logic                out_unsup
);
   localparam int HALF = DATA_W / 2;

   logic hit_w;
   logic good_w;
   assign hit_w  = (insn[OPC_HI:OPC_LO] == OPC_MINMAX);
   assign good_w = (insn[FMTA_HI:FMTA_LO] == FMT_FULL) &&
                   (insn[FMTB_HI:FMTB_LO] == FMT_FULL) &&
                   insn[BIT_BREG] && !insn[BIT_SAT] &&
                   (insn[BIT_ASGN] == insn[BIT_BSGN]);

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (out_valid || out_unsup) |-> $past(in_valid));

   assert_miss_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !hit_w) |=> (!out_valid && !out_unsup && $stable(out_result)));

   assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_unsup && $stable(out_result)));

   assert_flag_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && hit_w && !good_w) |=> (out_unsup && !out_valid && $stable(out_result)));

   assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(out_valid && out_unsup));

   assert_keep_low_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && hit_w && good_w && insn[SEC_HI:SEC_LO] == 3'd0)
      |=> (out_result[HALF-1:0] == $past(opc[HALF-1:0])));
endmodule

bind vid_minmax_unit vmm_checker #(.DATA_W(DATA_W)) u_vmm_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .insn       (insn),
   .opc        (opc),
   .out_valid  (out_valid),
   .out_result (out_result),
   .out_unsup  (out_unsup)
);

// File: tb/test_vid_minmax_unit.sv
module test_vid_minmax_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [63:0] insn;
   logic [31:0] opa, opb, opc;
   logic        out_valid;
   logic [31:0] out_result;
   logic        out_unsup;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   vid_minmax_unit i_vid_minmax_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
      .opa(opa), .opb(opb), .opc(opc),
      .out_valid(out_valid), .out_result(out_result), .out_unsup(out_unsup)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(input bit mx, input bit [2:0] op,
                                      input bit sa, input bit sb, input bit sd,
                                      input bit sat, input bit rb,
                                      input bit [1:0] fa, input bit [1:0] fb);
      logic [63:0] w;
      w = 64'h0000_0000_0000_00A5;
      w[63:57] = 7'b0011101;
      w[56] = mx; w[55] = sat; w[54] = sd; w[53:51] = op;
      w[50] = rb; w[49] = sb; w[48] = sa;
      w[38:37] = fa; w[30:29] = fb;
      return w;
   endfunction

   function automatic logic [63:0] good(input bit mx, input bit [2:0] op,
                                        input bit s, input bit sd);
      return mk(mx, op, s, s, sd, 1'b0, 1'b1, 2'b11, 2'b11);
   endfunction

   function automatic logic [31:0] pick(input logic [31:0] a, input logic [31:0] b,
                                        input bit s, input bit mx);
      bit lt;
      lt = s ? ($signed(a) < $signed(b)) : (a < b);
      return mx ? (lt ? b : a) : (lt ? a : b);
   endfunction

   function automatic logic [31:0] model(input logic [63:0] w, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] c);
      logic [31:0] p, r;
      p = pick(a, b, w[48], w[56]);
      r = c;
      case (w[53:51])
         3'd0: r[31:16] = p[15:0];
         3'd1: r[15:0]  = p[15:0];
         3'd2: r[7:0]   = p[7:0];
         3'd3: r[23:16] = p[7:0];
         3'd4: r = p + c;
         3'd5: r = pick(p, c, w[54], 1'b0);
         3'd6: r = pick(p, c, w[54], 1'b1);
         default: r = p;
      endcase
      return r;
   endfunction

   task automatic issue(input logic [63:0] w, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c);
      @(negedge clk);
      insn = w; opa = a; opb = b; opc = c; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_ok(input string req, input logic [63:0] w, input logic [31:0] a,
                         input logic [31:0] b, input logic [31:0] c);
      issue(w, a, b, c);
      chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
      chk({req, " unsup"}, {31'b0, out_unsup}, 32'd0);
      chk({req, " result"}, out_result, model(w, a, b, c));
   endtask

   task automatic run_bad(input string req, input logic [63:0] w);
      logic [31:0] held;
      held = out_result;
      issue(w, 32'h1111_1111, 32'h2222_2222, 32'h3333_3333);
      chk({req, " unsup"}, {31'b0, out_unsup}, 32'd1);
      chk({req, " valid"}, {31'b0, out_valid}, 32'd0);
      chk({req, " hold"}, out_result, held);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R2 reset valid", {31'b0, out_valid}, 32'd0);
      chk("R2 reset unsup", {31'b0, out_unsup}, 32'd0);
      chk("R2 reset result", out_result, 32'd0);
   endtask

   task automatic t_primary;
      for (int s = 0; s < 2; s++)
         for (int m = 0; m < 2; m++)
            run_ok("R3 primary", good(m[0], 3'd7, s[0], 1'b0), 32'hFFFF_FFF0, 32'h0000_0005, 32'h0);
      run_ok("R3 equal", good(1'b1, 3'd7, 1'b1, 1'b0), 32'h8000_0000, 32'h8000_0000, 32'h0);
   endtask

   task automatic t_merge;
      for (int k = 0; k < 4; k++) begin
         run_ok("R4 insert", good(1'b1, k[2:0], 1'b0, 1'b0), 32'h1234_5678, 32'h0000_0001, 32'hFFFF_FFFF);
         run_ok("R4 insert zero c", good(1'b0, k[2:0], 1'b0, 1'b0), 32'hCAFE_BEEF, 32'hDEAD_9A7C, 32'h0);
      end
   endtask

   task automatic t_add;
      run_ok("R5 add wrap", good(1'b1, 3'd4, 1'b0, 1'b0), 32'hFFFF_FFF0, 32'h1, 32'h0000_0020);
      run_ok("R5 add", good(1'b0, 3'd4, 1'b1, 1'b0), 32'h0000_0010, 32'hFFFF_FFFE, 32'h0000_0003);
   endtask

   task automatic t_second;
      for (int sd = 0; sd < 2; sd++) begin
         run_ok("R6 sec min", good(1'b0, 3'd5, 1'b0, sd[0]), 32'h0000_0004, 32'h0000_0009, 32'h8000_0001);
         run_ok("R6 sec max", good(1'b0, 3'd6, 1'b0, sd[0]), 32'h0000_0004, 32'h0000_0009, 32'h8000_0001);
         run_ok("R6 sec max src signed", good(1'b1, 3'd6, 1'b1, sd[0]), 32'hFFFF_0000, 32'h0000_0002, 32'hFFFF_FFFF);
      end
   endtask

   task automatic t_pass;
      run_ok("R7 pass", good(1'b1, 3'd7, 1'b0, 1'b1), 32'h0BAD_F00D, 32'h0000_0001, 32'hFFFF_FFFF);
   endtask

   task automatic t_unsup;
      run_ok("R8 setup", good(1'b1, 3'd7, 1'b0, 1'b0), 32'h5A5A_1234, 32'h0, 32'h0);
      run_bad("R8 fmt a", mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 2'b11));
      run_bad("R8 fmt b", mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b01));
      run_bad("R8 b imm", mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 2'b11));
      run_bad("R8 sign mix", mk(1'b1, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 2'b11));
      run_bad("R8 sat", mk(1'b1, 3'd7, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b11));
   endtask

   task automatic t_miss;
      logic [31:0] held;
      logic [63:0] w;
      held = out_result;
      w = good(1'b1, 3'd7, 1'b0, 1'b0);
      w[63:57] = 7'b0011100;
      issue(w, 32'h7777_7777, 32'h1, 32'h0);
      chk("R1 miss valid", {31'b0, out_valid}, 32'd0);
      chk("R1 miss unsup", {31'b0, out_unsup}, 32'd0);
      chk("R1 miss hold", out_result, held);
   endtask

   task automatic t_idle;
      logic [31:0] held;
      held = out_result;
      @(negedge clk);
      insn = good(1'b1, 3'd7, 1'b0, 1'b0); opa = 32'h9999_9999; in_valid = 1'b0;
      @(negedge clk);
      chk("R9 idle valid", {31'b0, out_valid}, 32'd0);
      chk("R9 idle unsup", {31'b0, out_unsup}, 32'd0);
      chk("R9 idle hold", out_result, held);
   endtask

   task automatic t_b2b;
      @(negedge clk);
      insn = good(1'b1, 3'd4, 1'b0, 1'b0); opa = 32'd5; opb = 32'd3; opc = 32'd1; in_valid = 1'b1;
      @(negedge clk);
      chk("R2 b2b first", out_result, 32'd6);
      insn = good(1'b0, 3'd7, 1'b0, 1'b0); opa = 32'd5; opb = 32'd3;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2 b2b second", out_result, 32'd3);
      chk("R2 b2b valid", {31'b0, out_valid}, 32'd1);
      @(negedge clk);
      chk("R2 b2b drop", {31'b0, out_valid}, 32'd0);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; insn = '0; opa = '0; opb = '0; opc = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_primary();
      t_merge();
      t_add();
      t_second();
      t_pass();
      t_unsup();
      t_miss();
      t_idle();
      t_b2b();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule